// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards a processor bus against cycles that never complete. It samples a data-enable strobe on every clock and counts how many consecutive clocks the strobe has been high. When that run gets longer than a programmed limit, the block treats the bus cycle as stalled. It can then force the ready handshake for one clock, which ends the cycle. It can also raise a bus-error output, either as a fixed two-clock pulse or as a latched level.

A small register port sets the limit and three mode bits. A latched bus-error level stays up until software reads the limit register. This lets the error line drive a processor exception input directly. The pulse form suits an external supervisor that counts events. A limit of zero turns the monitor off.

Top module: `bus_timeout_mon`

## Requirements
- R1: With a non-zero limit L, a timeout event occurs at the clock edge that samples the data-enable input high for the (L+1)-th consecutive time. Any clock that samples data-enable low clears the count.
- R2: The ready output goes high for exactly one clock after each timeout event, and only when mode bit 0 (ready enable) is 1.
- R3: The bus-error output responds to a timeout only when mode bit 1 (error enable) is 1.
- R4: At most one timeout event occurs per high period of data-enable. Another event needs data-enable to be sampled low first.
- R5: With mode bit 2 clear, the bus-error output is high for exactly two clocks. The pulse starts in the same clock as the forced ready.
- R6: With mode bit 2 set, the bus-error output rises with the timeout and stays high until a read of register address 0. A read of address 1 does not clear it.
- R7: A limit of 0 disables the monitor: no ready and no bus-error, however long data-enable stays high.
- R8: A write to address 0 stores the limit from the low CNT_W data bits. A write to address 1 stores the mode from data bits 2:0. A read of either address returns the stored value, zero-extended, on the read-data port after the read edge. The read-data port holds that value until the next read.
- R9: Synchronous reset clears the limit, the mode bits, the count, the read data, the ready output and the bus-error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| den | input | 1 | Data-enable strobe of the monitored bus |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 = limit, 1 = mode |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| rdy_force | output | 1 | Forced ready, one clock per timeout |
| bus_err | output | 1 | Bus-error output, pulse or latched level |

## Verification
The pulse-width properties assume that data-enable stays low for at least one clock between bus cycles, and that the mode is not switched from level to pulse while a level is latched. Under those conditions two error events can never overlap. The stimulus changes the limit and the mode only while data-enable is low and every pulse has ended. It clears every latched level with a read before it moves on. In the one test where data-enable pulses back to back, the gap is still a full clock.

// File: rtl/bto_pkg.sv
package bto_pkg;
  localparam int MODE_W = 3;
  localparam logic ADDR_LIMIT = 1'b0;
  localparam logic ADDR_MODE  = 1'b1;

  typedef struct packed {
    logic lvl;      // bit 2: latched error level
    logic berr_en;  // bit 1: error output enable
    logic rdy_en;   // bit 0: forced ready enable
  } mode_t;
endpackage

// File: rtl/bto_regs.sv
module bto_regs
  import bto_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  limit,
  output mode_t             mode,
  output logic              limit_read
);
  assign limit_read = rd && (addr == ADDR_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= '0;
      mode  <= '0;
      rdata <= '0;
    end else begin
      if (wr) begin
        if (addr == ADDR_LIMIT) limit <= wdata[CNT_W-1:0];
        else                    mode  <= mode_t'(wdata[MODE_W-1:0]);
      end
      if (rd) begin
        if (addr == ADDR_LIMIT) rdata <= DATA_W'(limit);
        else                    rdata <= DATA_W'(mode);
      end
    end
  end
endmodule

// File: rtl/bto_timer.sv
module bto_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             den,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);
  logic [CNT_W-1:0] run_cnt;
  logic             done;

  assign fire = den && (limit != '0) && !done && (run_cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      done    <= 1'b0;
    end else if (!den) begin
      run_cnt <= '0;
      done    <= 1'b0;
    end else begin
      if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
      if (fire) done <= 1'b1;
    end
  end
endmodule

// File: rtl/bto_err_out.sv
module bto_err_out
  import bto_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  mode_t mode,
  input  logic  limit_read,
  output logic  rdy_force,
  output logic  bus_err,
  output logic  latched
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] pulse_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_force  <= 1'b0;
      pulse_left <= '0;
      latched    <= 1'b0;
    end else begin
      rdy_force <= fire && mode.rdy_en;
      if (fire && mode.berr_en && !mode.lvl) pulse_left <= PW'(PULSE_LEN);
      else if (pulse_left != '0)             pulse_left <= pulse_left - 1'b1;
      if (fire && mode.berr_en && mode.lvl) latched <= 1'b1;
      else if (limit_read)                  latched <= 1'b0;
    end
  end

  assign bus_err = latched || (pulse_left != '0);
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import bto_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int DATA_W = (CNT_W > MODE_W) ? CNT_W : MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              den,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rdy_force,
  output logic              bus_err
);
  logic [CNT_W-1:0] cfg_limit;
  mode_t            cfg_mode;
  logic             limit_read;
  logic             fire;
  logic             err_latched;

  bto_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .limit(cfg_limit),
    .mode(cfg_mode), .limit_read(limit_read)
  );

  bto_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .den(den), .limit(cfg_limit), .fire(fire)
  );

  bto_err_out #(.PULSE_LEN(2)) u_err (
    .clk(clk), .rst(rst), .fire(fire), .mode(cfg_mode),
    .limit_read(limit_read), .rdy_force(rdy_force), .bus_err(bus_err),
    .latched(err_latched)
  );
endmodule

// File: rtl/bus_timeout_mon_chk.sv
module bus_timeout_mon_chk (
  input logic clk,
  input logic rst,
  input logic den,
  input logic limit_rd,
  input logic rdy_force,
  input logic bus_err,
  input logic limit_zero,
  input logic rdy_en,
  input logic berr_en,
  input logic latched
);
  p_ready_den_r1: assert property (@(posedge clk) disable iff (rst)
    rdy_force |-> $past(den));
  p_ready_single_r2: assert property (@(posedge clk) disable iff (rst)
    rdy_force |=> !rdy_force);
  p_ready_gated_r2: assert property (@(posedge clk) disable iff (rst)
    rdy_force |-> $past(rdy_en));
  p_berr_gated_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err) |-> $past(berr_en));
  p_pulse_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!latched && $rose(bus_err)) |=> bus_err);
  p_pulse_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (!latched && bus_err && $past(bus_err)) |=> !bus_err);
  p_level_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (latched && !limit_rd) |=> bus_err);
  p_zero_off_r7: assert property (@(posedge clk) disable iff (rst)
    limit_zero |=> !rdy_force);
endmodule

bind bus_timeout_mon bus_timeout_mon_chk u_chk (
  .clk(clk), .rst(rst), .den(den),
  .limit_rd(reg_rd && (reg_addr == 1'b0)),
  .rdy_force(rdy_force), .bus_err(bus_err),
  .limit_zero(cfg_limit == '0),
  .rdy_en(cfg_mode.rdy_en), .berr_en(cfg_mode.berr_en),
  .latched(err_latched)
);

// File: tb/sim_bus_timeout_mon.sv
module sim_bus_timeout_mon;
  localparam int CNT_W  = 4;
  localparam int DATA_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic den = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic rdy_force, bus_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_timeout_mon #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .den(den), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rdy_force(rdy_force), .bus_err(bus_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic a, input int d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = DATA_W'(d);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // One bus cycle: data-enable high for d samples, then low.
  task automatic run(input int lim, input int d, input int m);
    bit fires;
    fires = (lim != 0) && (d >= lim + 1);
    den = 1'b1;
    for (int i = 1; i <= d + 3; i++) begin
      int e_rdy, e_err;
      @(posedge clk); @(negedge clk);
      e_rdy = (m[0] && fires && i == lim + 1) ? 1 : 0;
      if (m[2]) e_err = (m[1] && fires && i >= lim + 1) ? 1 : 0;
      else      e_err = (m[1] && fires && (i == lim + 1 || i == lim + 2)) ? 1 : 0;
      check((lim == 0) ? "R7 ready" : "R1/R2 ready", rdy_force, e_rdy);
      check(m[2] ? "R3/R6 level" : "R3/R5 pulse", bus_err, e_err);
      den = (i < d);
    end
    if (m[2] && m[1] && fires) begin
      rd_reg(1'b1);
      check("R6 mode read keeps level", bus_err, 1);
      check("R8 mode readback", reg_rdata, m);
    end
    rd_reg(1'b0);
    check("R6 cleared by limit read", bus_err, 0);
    check("R8 limit readback", reg_rdata, lim);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset ready", rdy_force, 0);
    check("R9 reset berr", bus_err, 0);
    check("R9 reset rdata", reg_rdata, 0);
    rst = 1'b0;
    rd_reg(1'b0);
    check("R9 limit zero after reset", reg_rdata, 0);
    rd_reg(1'b1);
    check("R9 mode zero after reset", reg_rdata, 0);

    // Sweep every mode, every limit and several strobe lengths.
    for (int m = 0; m < 8; m++) begin
      wr_reg(1'b1, m);
      rd_reg(1'b1);
      check("R8 mode write", reg_rdata, m);
      for (int lim = 0; lim < 16; lim++) begin
        wr_reg(1'b0, lim);
        for (int k = 0; k < 3; k++) begin
          int d;
          d = (k == 0) ? lim : ((k == 1) ? lim + 1 : lim + 3);
          if (d == 0) d = 1;
          run(lim, d, m);
        end
      end
    end

    // R4: one event per high period, one low clock re-arms.
    wr_reg(1'b1, 3);
    wr_reg(1'b0, 2);
    begin
      int runlen;
      runlen = 0;
      den = 1'b1;
      for (int i = 1; i <= 14; i++) begin
        @(posedge clk); @(negedge clk);
        runlen = den ? runlen + 1 : 0;
        check("R4 ready per cycle", rdy_force, (runlen == 3) ? 1 : 0);
        den = (i + 1 <= 5) || (i + 1 >= 7 && i + 1 <= 11);
      end
      den = 1'b0;
    end

    // R9: reset mid-run clears programmed state.
    wr_reg(1'b1, 7);
    wr_reg(1'b0, 1);
    den = 1'b1;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    check("R6 level up before reset", bus_err, 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    den = 1'b0;
    check("R9 berr cleared by reset", bus_err, 0);
    rd_reg(1'b0);
    check("R9 limit cleared by reset", reg_rdata, 0);
    rd_reg(1'b1);
    check("R9 mode cleared by reset", reg_rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule